// File: doc/BRIEF.md
# Data Cache Lookup and Allocation Controller

This block decides, for every processor data access, whether a small set-associative cache can serve it and what traffic the access needs on the external memory side. Each request is compared against the tags of every way in the selected set. Loads that hit return the cached word. Stores that hit update the cached word. A store hit to a page marked write-through is also forwarded to memory as a single-word write.

On a miss, the outcome depends on the global cache enable and the page's cacheability. If the cache is enabled and the page is cacheable, the line is allocated. The round-robin victim is first written back if it is dirty, and a 32-byte line fill is then requested. In every other case the miss is sent through as a single-word read or a posted single-word write, and nothing is allocated.

Clearing the enable does not touch the resident lines, which keep serving hits. The processor holds its request while `stall` is high. A request completes on the clock edge where `stall` is low.

Top module: `dcache_lookup`

## Requirements
- R1: A load that hits completes in the cycle it is presented (`stall` low). `rd_valid` is 1 one cycle later with the cached word, and no memory read is issued.
- R2: A store that hits writes `req_wdata` into the cached word. A later load to that address returns the new value.
- R3: A store hit with `pg_wthru`=1 produces exactly one `mem_wr_req` pulse, one cycle after completion, carrying the word-aligned address and the store data. With `pg_wthru`=0 it produces no memory write.
- R4: A miss with `cache_on`=1 and `pg_cacheable`=1 raises `stall` and issues one `mem_rd_req` pulse with `mem_rd_line`=1 and an address whose low 5 bits are zero. The cache takes 8 response beats as words 0 to 7 of the line and then completes the request from the new line.
- R5: With `cache_on`=0, load hits and store hits behave exactly as in R1 and R2.
- R6: With `cache_on`=0, a load miss never allocates, even to a cacheable page. It issues one `mem_rd_req` with `mem_rd_line`=0 and the word address, and returns the single response word. Repeating the load issues another read.
- R7: With `cache_on`=1 and `pg_cacheable`=0, misses do not allocate. A load miss issues a single-word read (`mem_rd_line`=0). A store miss completes without stall and issues one single-word `mem_wr_req`.
- R8: Before filling, an allocating miss whose victim line is dirty writes the victim back. This takes 8 single-word writes, word 0 first, each at the victim's own line address plus 4 times the word index. The fill request follows.
- R9: Clearing `cache_on` does not invalidate or flush resident lines. A line filled while enabled still hits, with no memory traffic.
- R10: The victim way in a set follows round-robin order. After reset it starts at way 0 and moves to the next way on each fill into that set.
- R11: After reset, `stall`, `rd_valid`, `mem_rd_req` and `mem_wr_req` are 0, and no line is valid, so the first access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor access request, held while stall is high |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the access (word aligned) |
| req_wdata | input | 32 | Store data |
| pg_cacheable | input | 1 | Page may allocate in the cache |
| pg_wthru | input | 1 | Page uses write-through for store hits |
| cache_on | input | 1 | Global cache enable |
| stall | output | 1 | Request cannot complete this cycle |
| rd_valid | output | 1 | Load data valid (one cycle after completion) |
| rd_data | output | 32 | Load data |
| mem_rd_req | output | 1 | One-cycle read request to memory |
| mem_rd_line | output | 1 | 1 = 8-word line fill, 0 = single word |
| mem_rd_addr | output | 32 | Read address |
| mem_rsp_valid | input | 1 | Read response beat valid |
| mem_rsp_data | input | 32 | Read response word |
| mem_wr_req | output | 1 | One-cycle single-word write to memory |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 32 | Write data |

## Verification
The bench goes after the disabled-cache miss to a cacheable page. A design that ignored the enable would issue a line fill there, and a repeated load would then hit instead of reading memory again. It fills both ways of one set and then forces an eviction of a line dirtied by a write-back store. A design with a wrong victim order or a lost dirty bit would either evict the wrong line or skip, reorder or corrupt the eight write-back words. It also checks that the resident lines survive the enable being cleared, and that uncached store misses are posted without stalling.

// File: rtl/dcl_pkg.sv
`timescale 1ns/1ps
// Shared types for the data cache lookup controller.
package dcl_pkg;
    // Controller sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // lookups served, misses dispatched
        ST_EVICT = 2'd1,   // dirty victim being written back
        ST_FILL  = 2'd2,   // line fill beats being absorbed
        ST_NCRD  = 2'd3    // waiting for a non-allocating read word
    } ctl_state_t;
endpackage

// File: rtl/dcl_tags.sv
`timescale 1ns/1ps
// Tag, valid and dirty storage with a parallel way compare.
// Assumes: one lookup index per cycle, at most one dirty-set and one
// install per cycle, WAYS a power of two of at least 2.
module dcl_tags #(
    parameter int WAYS  = 2,
    parameter int SETS  = 4,
    parameter int TAG_W = 25,
    parameter int IDX_W = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] vic_way,
    output logic             vic_valid,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag,
    input  logic             dirty_set,
    input  logic [IDX_W-1:0] dirty_idx,
    input  logic [WAY_W-1:0] dirty_way,
    input  logic             inst_en,
    input  logic [IDX_W-1:0] inst_idx,
    input  logic [WAY_W-1:0] inst_way,
    input  logic [TAG_W-1:0] inst_tag
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [WAY_W-1:0] rr_q    [SETS];
    logic [WAYS-1:0]  match;

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    end

    // Encode the matching way (a tag is resident in at most one way).
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit       = |match;
    assign vic_way   = rr_q[lk_idx];
    assign vic_valid = valid_q[lk_idx][vic_way];
    assign vic_dirty = dirty_q[lk_idx][vic_way];
    assign vic_tag   = tag_q[lk_idx][vic_way];

    // State bits: valid, dirty and round-robin pointer per set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else begin
            if (dirty_set) dirty_q[dirty_idx][dirty_way] <= 1'b1;
            if (inst_en) begin
                valid_q[inst_idx][inst_way] <= 1'b1;
                dirty_q[inst_idx][inst_way] <= 1'b0;
                rr_q[inst_idx] <= (inst_way == WAY_W'(WAYS-1)) ? '0 : inst_way + 1'b1;
            end
        end
    end

    // Tag capture on line install.
    always_ff @(posedge clk) begin
        if (inst_en) tag_q[inst_idx][inst_way] <= inst_tag;
    end
endmodule

// File: rtl/dcl_data.sv
`timescale 1ns/1ps
// Word storage for all lines: one asynchronous read port, one write port.
// Assumes the address is {set, way, word} and the depth is 2**AW.
module dcl_data #(
    parameter int DATA_W = 32,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;
    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    // Single write per cycle from a store hit or a fill beat.
    always_ff @(posedge clk) begin
        if (we) mem[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/dcache_lookup.sv
`timescale 1ns/1ps
// Hit/miss and allocation control for a set-associative data cache.
// Hits are served whatever the enable says; a miss allocates only when
// the cache is on and the page is cacheable, otherwise it is passed to
// memory as one word. Dirty victims are written back before the fill.
// Assumes the processor holds the request while stall is high and that
// memory accepts a write every cycle.
module dcache_lookup #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WAYS       = 2,
    parameter int SETS       = 4,
    parameter int LINE_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              pg_cacheable,
    input  logic              pg_wthru,
    input  logic              cache_on,
    output logic              stall,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_rd_req,
    output logic              mem_rd_line,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    import dcl_pkg::*;

    localparam int BYTE_OFF = $clog2(DATA_W / 8);
    localparam int WORD_W   = $clog2(LINE_WORDS);
    localparam int OFF_W    = BYTE_OFF + WORD_W;
    localparam int IDX_W    = $clog2(SETS);
    localparam int WAY_W    = $clog2(WAYS);
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
    localparam int AW       = IDX_W + WAY_W + WORD_W;
    localparam logic [WORD_W-1:0] LAST      = WORD_W'(LINE_WORDS - 1);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'((1 << BYTE_OFF) - 1);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'((1 << OFF_W) - 1);

    ctl_state_t        state_q;
    logic [WORD_W-1:0] cnt_q;
    logic [IDX_W-1:0]  m_idx;
    logic [TAG_W-1:0]  m_tag;
    logic [TAG_W-1:0]  m_vtag;
    logic [WAY_W-1:0]  m_way;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WORD_W-1:0] req_word;
    logic              lk_hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  vic_way;
    logic              vic_valid;
    logic              vic_dirty;
    logic [TAG_W-1:0]  vic_tag;
    logic              idle;
    logic              can_alloc;
    logic              st_hit;
    logic              fill_beat;
    logic              dirty_set;
    logic              inst_en;
    logic [AW-1:0]     arr_raddr;
    logic [AW-1:0]     arr_waddr;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] arr_wdata;
    logic              arr_we;

    assign req_idx   = req_addr[OFF_W +: IDX_W];
    assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
    assign req_word  = req_addr[BYTE_OFF +: WORD_W];
    assign idle      = (state_q == ST_IDLE);
    assign can_alloc = cache_on && pg_cacheable;
    assign st_hit    = idle && req_valid && lk_hit && req_write;
    assign fill_beat = (state_q == ST_FILL) && mem_rsp_valid;
    assign dirty_set = st_hit && !pg_wthru;
    assign inst_en   = fill_beat && (cnt_q == LAST);

    dcl_tags #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(req_idx), .lk_tag(req_tag),
        .hit(lk_hit), .hit_way(hit_way),
        .vic_way(vic_way), .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
        .dirty_set(dirty_set), .dirty_idx(req_idx), .dirty_way(hit_way),
        .inst_en(inst_en), .inst_idx(m_idx), .inst_way(m_way), .inst_tag(m_tag)
    );

    // Array ports: eviction reads the victim, fill beats write the victim slot.
    assign arr_raddr = (state_q == ST_EVICT) ? {m_idx, m_way, cnt_q} : {req_idx, hit_way, req_word};
    assign arr_waddr = fill_beat ? {m_idx, m_way, cnt_q} : {req_idx, hit_way, req_word};
    assign arr_wdata = fill_beat ? mem_rsp_data : req_wdata;
    assign arr_we    = fill_beat || st_hit;

    dcl_data #(.DATA_W(DATA_W), .AW(AW)) u_data (
        .clk(clk), .rd_addr(arr_raddr), .rd_data(arr_rdata),
        .we(arr_we), .wr_addr(arr_waddr), .wr_data(arr_wdata)
    );

    // Stall: busy states hold the request; in idle only blocking misses stall.
    always_comb begin
        case (state_q)
            ST_IDLE: stall = req_valid && !lk_hit && (can_alloc || !req_write);
            ST_NCRD: stall = !mem_rsp_valid;
            default: stall = 1'b1;
        endcase
    end

    // Sequencer and registered outputs toward the processor and memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            m_idx       <= '0;
            m_tag       <= '0;
            m_vtag      <= '0;
            m_way       <= '0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            mem_rd_req  <= 1'b0;
            mem_rd_line <= 1'b0;
            mem_rd_addr <= '0;
            mem_wr_req  <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else begin
            rd_valid   <= 1'b0;
            mem_rd_req <= 1'b0;
            mem_wr_req <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (lk_hit) begin
                            if (!req_write) begin
                                rd_valid <= 1'b1;
                                rd_data  <= arr_rdata;
                            end else if (pg_wthru) begin
                                mem_wr_req  <= 1'b1;
                                mem_wr_addr <= req_addr & WORD_MASK;
                                mem_wr_data <= req_wdata;
                            end
                        end else if (can_alloc) begin
                            m_idx  <= req_idx;
                            m_tag  <= req_tag;
                            m_way  <= vic_way;
                            m_vtag <= vic_tag;
                            cnt_q  <= '0;
                            if (vic_valid && vic_dirty) begin
                                state_q <= ST_EVICT;
                            end else begin
                                mem_rd_req  <= 1'b1;
                                mem_rd_line <= 1'b1;
                                mem_rd_addr <= req_addr & LINE_MASK;
                                state_q     <= ST_FILL;
                            end
                        end else if (req_write) begin
                            mem_wr_req  <= 1'b1;
                            mem_wr_addr <= req_addr & WORD_MASK;
                            mem_wr_data <= req_wdata;
                        end else begin
                            mem_rd_req  <= 1'b1;
                            mem_rd_line <= 1'b0;
                            mem_rd_addr <= req_addr & WORD_MASK;
                            state_q     <= ST_NCRD;
                        end
                    end
                end
                ST_EVICT: begin
                    mem_wr_req  <= 1'b1;
                    mem_wr_addr <= {m_vtag, m_idx, cnt_q, {BYTE_OFF{1'b0}}};
                    mem_wr_data <= arr_rdata;
                    cnt_q       <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        mem_rd_req  <= 1'b1;
                        mem_rd_line <= 1'b1;
                        mem_rd_addr <= {m_tag, m_idx, {OFF_W{1'b0}}};
                        state_q     <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_rsp_valid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST) state_q <= ST_IDLE;
                    end
                end
                ST_NCRD: begin
                    if (mem_rsp_valid) begin
                        rd_valid <= 1'b1;
                        rd_data  <= mem_rsp_data;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dcache_lookup_chk.sv
`timescale 1ns/1ps
// Protocol checker for dcache_lookup, attached by bind.
// Assumes a synchronous active-low reset on rst_n.
module dcache_lookup_chk #(
    parameter int OFF_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             cache_on,
    input logic             pg_cacheable,
    input logic             idle,
    input logic             stall,
    input logic             rd_valid,
    input logic             mem_rd_req,
    input logic             mem_rd_line,
    input logic [OFF_W-1:0] rd_addr_low,
    input logic             mem_wr_req,
    input logic [1:0]       wr_addr_low
);
    // R4: a line fill is requested at a line-aligned address.
    p_fill_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_line) |-> (rd_addr_low == '0));

    // R4: read requests are single-cycle pulses.
    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R6: a single-word read only comes from an access that may not allocate.
    p_noalloc_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_line) |-> $past(!(cache_on && pg_cacheable)));

    // R1: load data only follows a load that completed on the previous edge.
    p_rdv_follows_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write && !stall));

    // R7: a store that cannot allocate is posted without stalling.
    p_store_posted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_valid && req_write && !(cache_on && pg_cacheable)) |-> !stall);

    // R3: memory writes are word aligned.
    p_wr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> (wr_addr_low == 2'b00));
endmodule

bind dcache_lookup dcache_lookup_chk #(.OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .cache_on(cache_on), .pg_cacheable(pg_cacheable), .idle(idle), .stall(stall),
    .rd_valid(rd_valid), .mem_rd_req(mem_rd_req), .mem_rd_line(mem_rd_line),
    .rd_addr_low(mem_rd_addr[OFF_W-1:0]), .mem_wr_req(mem_wr_req),
    .wr_addr_low(mem_wr_addr[1:0])
);

// File: tb/dcache_lookup_test.sv
`timescale 1ns/1ps
// Directed bench for dcache_lookup: one task per scenario.
module dcache_lookup_test;
    localparam int PERIOD = 10;
    localparam int HALF   = PERIOD / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        pg_cacheable = 1'b1, pg_wthru = 1'b0, cache_on = 1'b1;
    logic        stall, rd_valid, mem_rd_req, mem_rd_line, mem_wr_req;
    logic [31:0] rd_data, mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0, errors = 0;
    int rd_cnt = 0, line_cnt = 0, wr_cnt = 0;
    logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_data = '0;
    logic        last_rd_line = 1'b0;
    logic [31:0] wlog_addr [32];
    logic [31:0] wlog_data [32];

    always #(HALF) clk = ~clk;

    dcache_lookup uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .pg_cacheable(pg_cacheable),
        .pg_wthru(pg_wthru), .cache_on(cache_on), .stall(stall), .rd_valid(rd_valid),
        .rd_data(rd_data), .mem_rd_req(mem_rd_req), .mem_rd_line(mem_rd_line),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return a ^ 32'hC3C3_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: 1 ns after each edge, returns beats and logs requests.
    initial begin
        int beats_left = 0, beat = 0;
        logic [31:0] raddr = '0;
        forever begin
            @(posedge clk);
            #1;
            if (beats_left > 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = memf(raddr + 32'(4 * beat));
                beat++;
                beats_left--;
            end else begin
                mem_rsp_valid = 1'b0;
            end
            if (mem_rd_req) begin
                rd_cnt++;
                if (mem_rd_line) line_cnt++;
                last_rd_addr = mem_rd_addr;
                last_rd_line = mem_rd_line;
                raddr = mem_rd_addr;
                beat = 0;
                beats_left = mem_rd_line ? 8 : 1;
            end
            if (mem_wr_req) begin
                if (wr_cnt < 32) begin
                    wlog_addr[wr_cnt] = mem_wr_addr;
                    wlog_data[wr_cnt] = mem_wr_data;
                end
                wr_cnt++;
                last_wr_addr = mem_wr_addr;
                last_wr_data = mem_wr_data;
            end
        end
    end

    // One processor access, held until stall is low at an edge.
    task automatic cpu(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output logic rdv, output int cyc);
        bit done;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        cyc = 0; done = 0;
        while (!done && cyc < 2000) begin
            #(HALF - 1);
            done = !stall;
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        rd  = rd_data;
        rdv = rd_valid;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(stall == 0, "R11", "stall after reset", 32'(stall), 0);
        chk(rd_valid == 0, "R11", "rd_valid after reset", 32'(rd_valid), 0);
        chk(mem_rd_req == 0 && mem_wr_req == 0, "R11", "mem req after reset",
            32'({mem_rd_req, mem_wr_req}), 0);
    endtask

    task automatic t_fill_and_hit;
        logic [31:0] d; logic v; int c, r0;
        cache_on = 1; pg_cacheable = 1; pg_wthru = 0;
        r0 = line_cnt;
        cpu(0, 32'h100, 0, d, v, c);
        chk(line_cnt - r0 == 1, "R11", "first access misses and fills", 32'(line_cnt - r0), 1);
        chk(last_rd_addr == 32'h100 && last_rd_line, "R4", "fill address", last_rd_addr, 32'h100);
        chk(c > 8, "R4", "miss stalls through fill", 32'(c), 9);
        chk(v && d == memf(32'h100), "R4", "load after fill", d, memf(32'h100));
        r0 = rd_cnt;
        cpu(0, 32'h11C, 0, d, v, c);
        chk(c == 1 && rd_cnt == r0, "R1", "hit no stall no read", 32'(c), 1);
        chk(v && d == memf(32'h11C), "R1", "hit data word 7", d, memf(32'h11C));
    endtask

    task automatic t_store_hits;
        logic [31:0] d; logic v; int c, w0;
        w0 = wr_cnt;
        pg_wthru = 0;
        cpu(1, 32'h104, 32'hDEAD0001, d, v, c);
        chk(c == 1 && wr_cnt == w0, "R3", "write-back store hit no write", 32'(wr_cnt - w0), 0);
        cpu(0, 32'h104, 0, d, v, c);
        chk(v && d == 32'hDEAD0001, "R2", "store hit updates line", d, 32'hDEAD0001);
        pg_wthru = 1;
        cpu(1, 32'h108, 32'hBEEF0002, d, v, c);
        pg_wthru = 0;
        chk(wr_cnt - w0 == 1, "R3", "write-through store one write", 32'(wr_cnt - w0), 1);
        chk(last_wr_addr == 32'h108 && last_wr_data == 32'hBEEF0002, "R3",
            "write-through data", last_wr_data, 32'hBEEF0002);
        cpu(0, 32'h108, 0, d, v, c);
        chk(d == 32'hBEEF0002, "R2", "write-through store also updates line", d, 32'hBEEF0002);
    endtask

    task automatic t_rr_evict;
        logic [31:0] d; logic v; int c, w0, l0;
        logic [31:0] exp;
        w0 = wr_cnt; l0 = line_cnt;
        cpu(0, 32'h180, 0, d, v, c);
        chk(wr_cnt == w0 && line_cnt - l0 == 1, "R10", "second way filled without eviction",
            32'(wr_cnt - w0), 0);
        cpu(0, 32'h200, 0, d, v, c);
        chk(wr_cnt - w0 == 8, "R8", "dirty victim eight writes", 32'(wr_cnt - w0), 8);
        for (int i = 0; i < 8; i++) begin
            exp = (i == 1) ? 32'hDEAD0001 : (i == 2) ? 32'hBEEF0002 : memf(32'h100 + 32'(4 * i));
            chk(wlog_addr[w0 + i] == 32'h100 + 32'(4 * i), "R8", "writeback address",
                wlog_addr[w0 + i], 32'h100 + 32'(4 * i));
            chk(wlog_data[w0 + i] == exp, "R8", "writeback data", wlog_data[w0 + i], exp);
        end
        chk(last_rd_addr == 32'h200 && last_rd_line, "R8", "fill after writeback", last_rd_addr, 32'h200);
        chk(v && d == memf(32'h200), "R4", "new line data", d, memf(32'h200));
        l0 = rd_cnt;
        cpu(0, 32'h184, 0, d, v, c);
        chk(c == 1 && rd_cnt == l0, "R10", "way 1 line kept by round robin", 32'(rd_cnt - l0), 0);
    endtask

    task automatic t_disabled;
        logic [31:0] d; logic v; int c, r0, w0, l0;
        cache_on = 0; pg_cacheable = 1;
        r0 = rd_cnt; w0 = wr_cnt;
        cpu(0, 32'h208, 0, d, v, c);
        chk(c == 1 && rd_cnt == r0 && v && d == memf(32'h208), "R9",
            "resident line hits after disable", d, memf(32'h208));
        cpu(1, 32'h20C, 32'h1234_5678, d, v, c);
        cpu(0, 32'h20C, 0, d, v, c);
        chk(d == 32'h1234_5678 && wr_cnt == w0, "R5", "store hit while disabled", d, 32'h1234_5678);
        l0 = line_cnt;
        cpu(0, 32'h300, 0, d, v, c);
        chk(rd_cnt - r0 == 1 && !last_rd_line && last_rd_addr == 32'h300, "R6",
            "disabled miss single read", last_rd_addr, 32'h300);
        chk(v && d == memf(32'h300), "R6", "disabled miss data", d, memf(32'h300));
        cpu(0, 32'h300, 0, d, v, c);
        chk(rd_cnt - r0 == 2 && line_cnt == l0, "R6", "repeat miss reads again", 32'(rd_cnt - r0), 2);
        cache_on = 1;
    endtask

    task automatic t_noncache;
        logic [31:0] d; logic v; int c, r0, w0;
        cache_on = 1; pg_cacheable = 0;
        r0 = rd_cnt; w0 = wr_cnt;
        cpu(0, 32'h404, 0, d, v, c);
        chk(rd_cnt - r0 == 1 && !last_rd_line && last_rd_addr == 32'h404, "R7",
            "uncached load single read", last_rd_addr, 32'h404);
        chk(v && d == memf(32'h404), "R7", "uncached load data", d, memf(32'h404));
        cpu(1, 32'h440, 32'hCAFE_0440, d, v, c);
        chk(c == 1 && wr_cnt - w0 == 1, "R7", "uncached store posted", 32'(c), 1);
        chk(last_wr_addr == 32'h440 && last_wr_data == 32'hCAFE_0440, "R7",
            "uncached store data", last_wr_data, 32'hCAFE_0440);
        pg_cacheable = 1;
    endtask

    initial begin
        #(PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_and_hit();
        t_store_hits();
        t_rr_evict();
        t_disabled();
        t_noncache();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule